// File: doc/BRIEF.md
# Serial Line Break and Idle Detector

This block sits next to an asynchronous frame receiver and watches the same, already synchronized, serial line. It reports two line conditions that the receiver itself does not see. The first is a break: the line stayed low for at least one whole frame time. The second is idle: the line stayed high for one whole frame time. While the line stays high, idle is reported again after every further frame time. An optional inversion input swaps the sense of the line before any measurement is made.

The frame time is computed at run time from four inputs: the cycles-per-bit divisor, the number of data bits, the parity enable and the stop-bit length. The stop-bit length may be a fractional number of bits. The receiver gives the block a frame-done strobe and the age of the frame that just ended. The block uses these to align its idle timing to that frame instead of to the line's rising edge. Each condition comes out as a single-cycle pulse, together with a duration: for a break, the length of the low run; for idle, the length of the high run.

Top module: `line_cond_detect`

## Requirements
- R1: The frame time F in clock cycles is ceil(H × bit_cycles_i / 2), where H = 2 × (1 + data_bits_i + parity_en_i) + stop_halves_i. data_bits_i is a plain binary count from 5 to 9. stop_halves_i encodes 0, 0.5, 1 and 1.5 stop bits as the values 0, 1, 2 and 3. F follows a configuration change one clock later.
- R2: The line level is sampled at each rising clock edge. A sample of low that follows a sample of high starts a new low-run measurement at 1. Any earlier low run is discarded, so only the most recent low run is ever judged.
- R3: On the first high sample after a low run of L samples with L ≥ F, break_o pulses for exactly one cycle and break_len_o becomes L. Both are visible just after that clock edge.
- R4: A low run shorter than F produces no break pulse, and break_len_o keeps its previous value.
- R5: While the line is high, an idle interval runs. idle_o pulses each time the interval reaches its target, and the interval then restarts at zero with target F. An interval started by a rising edge counts that first high sample as 1, so idle pulses come every F cycles. idle_run_o then reports the number of consecutive high samples up to and including that one.
- R6: A low sample cancels the idle interval and clears the high-run count. The next interval starts with the next high sample.
- R7: When frame_done_i is sampled together with a high line, the idle interval is set to frame_age_i with a target of 2F. The next idle pulse therefore comes one frame time after the end of that frame. When frame_done_i is sampled with a low line, it has no effect.
- R8: The low-run count, the idle interval count and the high-run count saturate at 2^CNT_W − 1 instead of wrapping. A longer break reports break_len_o = 2^CNT_W − 1.
- R9: With invert_i = 1, the level measured is the inverse of line_i. All break and idle rules then apply to that inverted level.
- R10: While rst is high, both pulses and both durations are 0. The line is treated as high before the first sample after reset, so a low first sample begins a low run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| line_i | input | 1 | Synchronized serial line |
| invert_i | input | 1 | 1 = measure the inverted line |
| bit_cycles_i | input | BIT_W | Clock cycles per bit |
| data_bits_i | input | 4 | Data bits per frame (5..9) |
| parity_en_i | input | 1 | 1 = frame carries a parity bit |
| stop_halves_i | input | 2 | Stop length in half bits (0..3) |
| frame_done_i | input | 1 | Receiver accepted a frame's stop bit |
| frame_age_i | input | CNT_W | Cycles since that frame's start edge |
| break_o | output | 1 | One-cycle break pulse |
| break_len_o | output | CNT_W | Length of the low run that caused the last break |
| idle_o | output | 1 | One-cycle idle pulse |
| idle_run_o | output | CNT_W | High-run length at the last idle pulse |

## Verification
A wrong internal count shows up at the ports within one frame time. An off-by-one in the low-run count moves the break boundary, so a low run of exactly F or F−1 samples flips break_o on the very next rising edge and puts the wrong value on break_len_o. A stale or wrongly seeded idle interval shifts idle pulses away from their expected cycle. The scoreboard compares every single cycle against an independent cycle model, so even a one-cycle shift is reported at the first pulse after it. A wrap instead of saturation would show as a small break_len_o after a very long low run.

// File: rtl/lcd_pkg.sv
package lcd_pkg;

    // Frame shape as seen by the detector
    typedef struct packed {
        logic [3:0] data_bits;   // 5..9
        logic       parity;      // parity bit present
        logic [1:0] stop_halves; // stop length in half bits
    } frame_shape_t;

    localparam int HALF_W = 5;   // enough for 2*(1+9+1)+3 = 25

    // Frame length in half-bit units
    function automatic logic [HALF_W-1:0] half_bit_count(frame_shape_t s);
        logic [HALF_W-1:0] bits;
        bits = HALF_W'(s.data_bits) + HALF_W'(1) + HALF_W'(s.parity);
        return (bits << 1) + HALF_W'(s.stop_halves);
    endfunction

endpackage

// File: rtl/frame_len_calc.sv
module frame_len_calc
    import lcd_pkg::*;
#(
    parameter int BIT_W = 12,
    parameter int CNT_W = 20
) (
    input  logic             clk,
    input  logic             rst,
    input  frame_shape_t     shape,
    input  logic [BIT_W-1:0] bit_cycles,
    output logic [CNT_W-1:0] flen_o
);
    localparam int PW = BIT_W + HALF_W;
    localparam int WW = ((PW > CNT_W) ? PW : CNT_W) + 1;
    localparam logic [WW-1:0] CAP = WW'({CNT_W{1'b1}});

    logic [PW-1:0]    product;
    logic [WW-1:0]    rounded;
    logic [CNT_W-1:0] flen_d;

    always_comb begin
        product = PW'(half_bit_count(shape)) * PW'(bit_cycles);
        rounded = (WW'(product) + WW'(1)) >> 1;
        flen_d  = (rounded > CAP) ? CNT_W'(CAP) : CNT_W'(rounded);
    end

    // Loaded every cycle, also in reset, so it is valid when reset ends
    always_ff @(posedge clk) flen_o <= flen_d;

    assert_flen_floor_R1: assert property (@(posedge clk) disable iff (rst)
        ($past(bit_cycles) != '0) |-> (flen_o >= CNT_W'(6)));

endmodule

// File: rtl/break_meter.sv
module break_meter #(
    parameter int CNT_W = 20
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             lvl,
    input  logic [CNT_W-1:0] flen,
    output logic             break_o,
    output logic [CNT_W-1:0] break_len_o
);
    localparam logic [CNT_W-1:0] MAXC = '1;

    logic             prev_hi;
    logic [CNT_W-1:0] low_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_hi     <= 1'b1;
            low_cnt     <= '0;
            break_o     <= 1'b0;
            break_len_o <= '0;
        end else begin
            prev_hi <= lvl;
            break_o <= 1'b0;
            if (!lvl) begin
                if (prev_hi)              low_cnt <= CNT_W'(1);
                else if (low_cnt != MAXC) low_cnt <= low_cnt + 1'b1;
            end else if (!prev_hi && (low_cnt >= flen)) begin
                break_o     <= 1'b1;
                break_len_o <= low_cnt;
            end
        end
    end

    assert_break_long_R3: assert property (@(posedge clk) disable iff (rst)
        break_o |-> (break_len_o >= $past(flen)));
    assert_break_on_rise_R3: assert property (@(posedge clk) disable iff (rst)
        break_o |-> $past(lvl));
    assert_fall_restart_R2: assert property (@(posedge clk) disable iff (rst)
        (!lvl && prev_hi) |=> (low_cnt == CNT_W'(1)));
    assert_low_no_wrap_R8: assert property (@(posedge clk) disable iff (rst)
        (!lvl && !prev_hi && low_cnt == MAXC) |=> (low_cnt == MAXC));

endmodule

// File: rtl/idle_meter.sv
module idle_meter #(
    parameter int CNT_W = 20
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             lvl,
    input  logic [CNT_W-1:0] flen,
    input  logic             seed,
    input  logic [CNT_W-1:0] seed_age,
    output logic             idle_o,
    output logic [CNT_W-1:0] idle_run_o
);
    localparam logic [CNT_W-1:0] MAXC = '1;

    logic             active;
    logic [CNT_W-1:0] cnt, cnt_n, run, run_n;
    logic [CNT_W:0]   tgt, tgt_cur;

    always_comb begin
        cnt_n   = !active ? CNT_W'(1) : ((cnt == MAXC) ? cnt : cnt + 1'b1);
        tgt_cur = active ? tgt : {1'b0, flen};
        run_n   = (run == MAXC) ? run : run + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            active     <= 1'b0;
            cnt        <= '0;
            tgt        <= '0;
            run        <= '0;
            idle_o     <= 1'b0;
            idle_run_o <= '0;
        end else begin
            idle_o <= 1'b0;
            if (!lvl) begin
                active <= 1'b0;
                cnt    <= '0;
                run    <= '0;
            end else begin
                run    <= run_n;
                active <= 1'b1;
                if (seed) begin
                    cnt <= seed_age;
                    tgt <= {flen, 1'b0};
                end else if ({1'b0, cnt_n} >= tgt_cur) begin
                    idle_o     <= 1'b1;
                    idle_run_o <= run_n;
                    cnt        <= '0;
                    tgt        <= {1'b0, flen};
                end else begin
                    cnt <= cnt_n;
                    tgt <= tgt_cur;
                end
            end
        end
    end

    assert_idle_needs_high_R5: assert property (@(posedge clk) disable iff (rst)
        idle_o |-> $past(lvl));
    assert_low_cancels_R6: assert property (@(posedge clk) disable iff (rst)
        !lvl |=> (!active && !idle_o));
    assert_run_no_wrap_R8: assert property (@(posedge clk) disable iff (rst)
        (lvl && run == MAXC) |=> (run == MAXC));

endmodule

// File: rtl/line_cond_detect.sv
module line_cond_detect
    import lcd_pkg::*;
#(
    parameter int BIT_W = 12,
    parameter int CNT_W = 20
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             line_i,
    input  logic             invert_i,
    input  logic [BIT_W-1:0] bit_cycles_i,
    input  logic [3:0]       data_bits_i,
    input  logic             parity_en_i,
    input  logic [1:0]       stop_halves_i,
    input  logic             frame_done_i,
    input  logic [CNT_W-1:0] frame_age_i,
    output logic             break_o,
    output logic [CNT_W-1:0] break_len_o,
    output logic             idle_o,
    output logic [CNT_W-1:0] idle_run_o
);
    frame_shape_t     shape;
    logic             level;
    logic [CNT_W-1:0] flen;

    assign shape = '{data_bits: data_bits_i, parity: parity_en_i,
                     stop_halves: stop_halves_i};
    assign level = line_i ^ invert_i;   // R9

    frame_len_calc #(.BIT_W(BIT_W), .CNT_W(CNT_W)) u_len (
        .clk(clk), .rst(rst), .shape(shape), .bit_cycles(bit_cycles_i),
        .flen_o(flen));

    break_meter #(.CNT_W(CNT_W)) u_brk (
        .clk(clk), .rst(rst), .lvl(level), .flen(flen),
        .break_o(break_o), .break_len_o(break_len_o));

    idle_meter #(.CNT_W(CNT_W)) u_idle (
        .clk(clk), .rst(rst), .lvl(level), .flen(flen),
        .seed(frame_done_i), .seed_age(frame_age_i),
        .idle_o(idle_o), .idle_run_o(idle_run_o));

    assert_pulses_exclusive_R5: assert property (@(posedge clk) disable iff (rst)
        (flen > CNT_W'(1)) |-> !(break_o && idle_o));

endmodule

// File: tb/sim_line_cond_detect.sv
module sim_line_cond_detect;
    timeunit 1ns;
    timeprecision 100ps;

    localparam int BW   = 6;
    localparam int CW   = 8;
    localparam int MAXV = (1 << CW) - 1;

    logic          clk = 1'b0;
    logic          rst;
    logic          line_i, invert_i, parity_en_i, frame_done_i;
    logic [BW-1:0] bit_cycles_i;
    logic [3:0]    data_bits_i;
    logic [1:0]    stop_halves_i;
    logic [CW-1:0] frame_age_i;
    logic          break_o, idle_o;
    logic [CW-1:0] break_len_o, idle_run_o;

    always #2.5 clk = ~clk;

    line_cond_detect #(.BIT_W(BW), .CNT_W(CW)) u0 (
        .clk(clk), .rst(rst), .line_i(line_i), .invert_i(invert_i),
        .bit_cycles_i(bit_cycles_i), .data_bits_i(data_bits_i),
        .parity_en_i(parity_en_i), .stop_halves_i(stop_halves_i),
        .frame_done_i(frame_done_i), .frame_age_i(frame_age_i),
        .break_o(break_o), .break_len_o(break_len_o),
        .idle_o(idle_o), .idle_run_o(idle_run_o));

    typedef struct {
        int cyc;
        bit brk;
        int blen;
        bit idl;
        int run;
    } exp_t;

    exp_t  q[$];
    int    cyc = 0;
    int    checks = 0;
    int    errors = 0;
    string phase = "R10";

    // reference state, derived from the requirements
    bit m_prev = 1, m_act = 0;
    int m_low = 0, m_cnt = 0, m_tgt = 0, m_run = 0, m_blen = 0, m_irun = 0;

    always @(posedge clk) cyc <= cyc + 1;

    function automatic int sat(int v);
        return (v > MAXV) ? MAXV : v;
    endfunction

    function automatic int frame_cycles();
        int h = 2 * (1 + int'(data_bits_i) + int'(parity_en_i)) + int'(stop_halves_i);
        return sat((h * int'(bit_cycles_i) + 1) / 2);
    endfunction

    task automatic check(bit ok, string req, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s [%s] actual=%0d expected=%0d at cycle %0d",
                     req, phase, act, exp, cyc);
        end
    endtask

    // driver: one sample, expectation pushed for the coming edge
    task automatic step(bit line, bit fd, int age);
        int   f;
        bit   lv;
        int   n;
        exp_t e;
        line_i       = line;
        frame_done_i = fd;
        frame_age_i  = CW'(age);
        f  = frame_cycles();
        lv = line ^ invert_i;
        e.cyc = cyc + 1; e.brk = 0; e.idl = 0;
        if (!lv) m_low = m_prev ? 1 : sat(m_low + 1);
        else if (!m_prev && m_low >= f) begin e.brk = 1; m_blen = m_low; end
        m_prev = lv;
        if (!lv) begin
            m_act = 0; m_run = 0; m_cnt = 0;
        end else begin
            m_run = sat(m_run + 1);
            if (fd) begin
                m_act = 1; m_cnt = age; m_tgt = 2 * f;
            end else begin
                n = m_act ? sat(m_cnt + 1) : 1;
                if (!m_act) m_tgt = f;
                m_act = 1;
                if (n >= m_tgt) begin
                    e.idl = 1; m_cnt = 0; m_tgt = f; m_irun = m_run;
                end else m_cnt = n;
            end
        end
        e.blen = m_blen; e.run = m_irun;
        q.push_back(e);
        @(negedge clk);
    endtask

    task automatic hold(bit line, int n);
        for (int i = 0; i < n; i++) step(line, 1'b0, 0);
    endtask

    // monitor: pops and compares as results appear
    always @(negedge clk) begin
        if (!rst && q.size() > 0 && q[0].cyc == cyc) begin
            exp_t e;
            e = q.pop_front();
            check(break_o == e.brk, e.brk ? "R3" : "R4", int'(break_o), int'(e.brk));
            check(int'(break_len_o) == e.blen, (e.blen == MAXV) ? "R8" : "R3",
                  int'(break_len_o), e.blen);
            check(idle_o == e.idl, "R5", int'(idle_o), int'(e.idl));
            check(int'(idle_run_o) == e.run, "R5", int'(idle_run_o), e.run);
        end
    end

    bit finished = 0;

    initial begin
        #(5.0 * 150000);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        rst = 1; line_i = 1; invert_i = 0; frame_done_i = 0; frame_age_i = '0;
        bit_cycles_i = 2; data_bits_i = 8; parity_en_i = 0; stop_halves_i = 2; // F = 20
        repeat (4) @(negedge clk);
        // R10: reset state
        check(!break_o && !idle_o, "R10", int'(break_o) + int'(idle_o), 0);
        check(break_len_o == 0 && idle_run_o == 0, "R10",
              int'(break_len_o) + int'(idle_run_o), 0);
        rst = 0;

        phase = "R5 repeat idle";      hold(1, 45);
        phase = "R4 short low";        hold(0, 19); hold(1, 3);
        phase = "R3 exact frame low";  hold(0, 20); hold(1, 25);
        phase = "R2 restart on fall";  hold(0, 10); hold(1, 2); hold(0, 19); hold(1, 2);
        hold(0, 20); hold(1, 2);
        phase = "R6 low cancels idle"; hold(1, 15); hold(0, 1); hold(1, 21);
        phase = "R7 seed";             hold(0, 3); hold(1, 5); step(1, 1, 12); hold(1, 50);
        phase = "R7 seed while low";   hold(0, 4); step(0, 1, 39); hold(0, 2); hold(1, 20);

        // R1: 7 data, parity, half stop bit, 3 cycles per bit -> F = 29
        phase = "R1 fractional stop";
        hold(0, 1);
        bit_cycles_i = 3; data_bits_i = 7; parity_en_i = 1; stop_halves_i = 1;
        hold(0, 27); hold(1, 3);
        hold(0, 29); hold(1, 30);
        // R1: 5 data, no parity, no stop -> F = 12
        phase = "R1 zero stop";
        hold(0, 1);
        bit_cycles_i = 2; data_bits_i = 5; parity_en_i = 0; stop_halves_i = 0;
        hold(0, 10); hold(1, 2); hold(0, 12); hold(1, 13);

        phase = "R9 inverted line";
        invert_i = 1;
        hold(1, 14); hold(0, 25); hold(1, 11); hold(0, 1);
        invert_i = 0;
        hold(1, 3);

        phase = "R8 saturation";       hold(0, 300); hold(1, 14);

        repeat (2) @(negedge clk);
        check(q.size() == 0, "R3", q.size(), 0);
        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule